// File: doc/BRIEF.md
# MAC Statistics Counter Bank

A bank of event counters for a network MAC. Each counter advances by one on every clock in which its event input is high: good unicast frames received, CRC errors, alignment errors, and similar. Software reaches the bank through a simple word-addressed register port. A read carries a four-bit byte-lane strobe, and only the enabled lanes return data. The read value appears on `rdata` one clock after the read request.

A control word sets the operating mode. It can hold every counter still, clear a counter when its low byte is read, pin counters at their maximum value instead of wrapping, and clear the whole bank in one write. Each counter has a status flag. The flag goes up when the counter's top bit becomes 1, which is half of its range. The flag drops only when that counter is read with byte lane 0 enabled. A mask register chooses which flags may raise the interrupt line.

Register map (word addresses): 0 control, 1 status (bit i belongs to counter i), 2 interrupt mask (bit i belongs to counter i), 8+i counter i.

Top module: `stat_ctr_bank`

## Requirements
- R1: After reset the control word, the mask, the status flags and every counter read as zero, and `irq` is low.
- R2: Writing control bit 0 as 1 makes that bit read back as 1 for exactly one clock. At the end of that clock every counter is zero, and the bit then reads 0.
- R3: Each clock with `evt_i[i]` high adds one to counter i. A read of word 8+i returns the counter zero-extended on `rdata` in the following cycle. A byte of `rdata` whose `rd_lane` strobe is low reads zero.
- R4: While control bit 3 (freeze) is 1, event pulses change no counter.
- R5: While control bit 1 (stop rollover) is 1, a counter at its all-ones value stays there when more events arrive.
- R6: With stop rollover at 0, a counter at all-ones wraps to zero on the next event. The default counter width is 32 bits.
- R7: Status bit i becomes 1 in the clock in which the top bit of counter i changes from 0 to 1.
- R8: A status bit stays set until counter i is read with `rd_lane[0]` high. Reads without lane 0, later events and wrap-around leave it set.
- R9: `irq` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 suppresses that status bit.
- R10: If an event arrives in the same clock as a clearing read of that counter, the read returns the value before the clear and the counter ends at 1.
- R11: While control bit 2 (clear on read) is 1, a read of counter i with `rd_lane[0]` high leaves it at zero. This also happens under freeze. A read without lane 0 does not clear.
- R12: Control bits 31:4 read as zero. Writes to the counter and status addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | N_CTR | One-cycle event pulse per counter |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rd_lane | input | 4 | Byte-lane enables for a read |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The event input and the clearing read can land on the same counter in the same clock. The bench drives `evt_i`, `rd_en` and lane 0 together at one falling edge. It then expects `rdata` to hold the pre-clear count and a follow-up read to return 1. A second collision comes from the global clear: the read issued in the very clock that the self-clearing bit is live must show that bit set, while the counters read back as zero from the next read on. Clear-on-read under freeze is also provoked: the first read returns the frozen value and the second returns zero, even though events keep arriving.

// File: rtl/stat_ctr_pkg.sv
package stat_ctr_pkg;

  // Control word, packed so that bit 0 is the global clear and bit 3 freeze.
  typedef struct packed {
    logic frz;
    logic ror;
    logic stop_roll;
    logic glob_clr;
  } ctl_t;

  localparam int unsigned CTL_W        = 4;
  localparam int unsigned REG_CTL      = 0;
  localparam int unsigned REG_STAT     = 1;
  localparam int unsigned REG_MASK     = 2;
  localparam int unsigned REG_CTR_BASE = 8;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned LANES        = DATA_W / 8;

endpackage

// File: rtl/stat_ctr_regs.sv
module stat_ctr_regs
  import stat_ctr_pkg::*;
#(
  parameter int unsigned N_CTR  = 4,
  parameter int unsigned CTR_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [LANES-1:0]        rd_lane,
  input  logic [N_CTR*CTR_W-1:0]  cnt_flat,
  input  logic [N_CTR-1:0]        status,
  output ctl_t                    ctl,
  output logic [N_CTR-1:0]        mask,
  output logic [N_CTR-1:0]        rd_hit,
  output logic [DATA_W-1:0]       rdata
);

  ctl_t              ctl_q, ctl_d;
  logic              ctl_en;
  logic [N_CTR-1:0]  mask_q, mask_d;
  logic              mask_en;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] lane_bits;

  // Byte-lane expansion of the read strobe.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_bits[b*8 +: 8] = {8{rd_lane[b]}};
  end

  // Lane-0 read hit per counter.
  for (genvar i = 0; i < N_CTR; i++) begin : g_hit
    assign rd_hit[i] = rd_en && rd_lane[0] && (addr == ADDR_W'(REG_CTR_BASE + i));
  end

  // Next state: control and mask.
  always_comb begin
    ctl_d          = ctl_q;
    ctl_d.glob_clr = 1'b0;
    ctl_en         = ctl_q.glob_clr;
    if (wr_en && addr == ADDR_W'(REG_CTL)) begin
      ctl_d  = ctl_t'(wdata[CTL_W-1:0]);
      ctl_en = 1'b1;
    end
    mask_en = wr_en && (addr == ADDR_W'(REG_MASK));
    mask_d  = wdata[N_CTR-1:0];
  end

  // Next state: read data.
  always_comb begin
    word = '0;
    if (addr == ADDR_W'(REG_CTL))  word[CTL_W-1:0] = ctl_q;
    if (addr == ADDR_W'(REG_STAT)) word[N_CTR-1:0] = status;
    if (addr == ADDR_W'(REG_MASK)) word[N_CTR-1:0] = mask_q;
    for (int i = 0; i < N_CTR; i++) begin
      if (addr == ADDR_W'(REG_CTR_BASE + i)) word[CTR_W-1:0] = cnt_flat[i*CTR_W +: CTR_W];
    end
    rdata_d = word & lane_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (ctl_en)  ctl_q   <= ctl_d;
      if (mask_en) mask_q  <= mask_d;
      if (rd_en)   rdata_q <= rdata_d;
    end
  end

  assign ctl   = ctl_q;
  assign mask  = mask_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
  parameter int unsigned CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             frz,
  input  logic             ror,
  input  logic             stop_roll,
  input  logic             glob_clr,
  input  logic             lane0_rd,
  output logic [CTR_W-1:0] cnt,
  output logic             stat
);

  localparam logic [CTR_W-1:0] MAX_V = '1;

  logic [CTR_W-1:0] cnt_q, cnt_d, base;
  logic             cnt_en, clr_rd, bump;
  logic             stat_q, stat_d;

  always_comb begin
    clr_rd = lane0_rd && ror;
    bump   = evt && !frz;
    base   = clr_rd ? '0 : cnt_q;
    cnt_en = glob_clr || clr_rd || bump;
    cnt_d  = base;
    if (glob_clr) begin
      cnt_d = '0;
    end else if (bump) begin
      if (stop_roll && base == MAX_V) cnt_d = base;
      else                            cnt_d = base + 1'b1;
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (lane0_rd) stat_d = 1'b0;
    if (cnt_en && cnt_d[CTR_W-1] && !cnt_q[CTR_W-1]) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign cnt  = cnt_q;
  assign stat = stat_q;

endmodule

// File: rtl/stat_ctr_bank.sv
module stat_ctr_bank
  import stat_ctr_pkg::*;
#(
  parameter int unsigned N_CTR  = 4,
  parameter int unsigned CTR_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CTR-1:0]  evt_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        rd_lane,
  output logic [31:0]       rdata,
  output logic              irq
);

  logic [1:0]             rst_sync;
  logic                   rst_sync_n;
  ctl_t                   ctl;
  logic [N_CTR-1:0]       mask;
  logic [N_CTR-1:0]       status;
  logic [N_CTR-1:0]       rd_hit;
  logic [N_CTR*CTR_W-1:0] cnt_flat;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  stat_ctr_regs #(
    .N_CTR (N_CTR),
    .CTR_W (CTR_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_lane (rd_lane),
    .cnt_flat(cnt_flat),
    .status  (status),
    .ctl     (ctl),
    .mask    (mask),
    .rd_hit  (rd_hit),
    .rdata   (rdata)
  );

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    stat_ctr_cell #(.CTR_W(CTR_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .evt      (evt_i[i]),
      .frz      (ctl.frz),
      .ror      (ctl.ror),
      .stop_roll(ctl.stop_roll),
      .glob_clr (ctl.glob_clr),
      .lane0_rd (rd_hit[i]),
      .cnt      (cnt_flat[i*CTR_W +: CTR_W]),
      .stat     (status[i])
    );
  end

  assign irq = |(status & ~mask);

endmodule

// File: rtl/stat_ctr_bank_chk.sv
module stat_ctr_bank_chk
  import stat_ctr_pkg::*;
#(
  parameter int unsigned N_CTR = 4,
  parameter int unsigned CTR_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input ctl_t                   ctl,
  input logic [N_CTR-1:0]       mask,
  input logic [N_CTR-1:0]       status,
  input logic [N_CTR-1:0]       rd_hit,
  input logic [N_CTR*CTR_W-1:0] cnt_flat,
  input logic                   irq
);

  localparam logic [CTR_W-1:0] MAX_V = '1;

  p_glob_clr_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.glob_clr |=> !ctl.glob_clr);

  p_glob_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.glob_clr |=> (cnt_flat == '0));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  for (genvar i = 0; i < N_CTR; i++) begin : g_chk
    p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.frz && !ctl.glob_clr && !(rd_hit[i] && ctl.ror))
        |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));

    p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.stop_roll && !ctl.glob_clr && !(rd_hit[i] && ctl.ror)
        && cnt_flat[i*CTR_W +: CTR_W] == MAX_V)
        |=> (cnt_flat[i*CTR_W +: CTR_W] == MAX_V));

    p_status_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_flat[i*CTR_W + CTR_W - 1]) |-> status[i]);
  end

endmodule

bind stat_ctr_bank stat_ctr_bank_chk #(
  .N_CTR(N_CTR),
  .CTR_W(CTR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ctl     (ctl),
  .mask    (mask),
  .status  (status),
  .rd_hit  (rd_hit),
  .cnt_flat(cnt_flat),
  .irq     (irq)
);

// File: tb/test_stat_ctr_bank.sv
`timescale 1ns/1ps
module test_stat_ctr_bank;

  localparam int N_CTR  = 4;
  localparam int CTR_W  = 8;
  localparam int ADDR_W = 4;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EV = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  adr;
    logic [31:0] data;  // write data, or {count[15:8], evt mask[3:0]}
    logic [3:0]  lane;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{K_RD, 4'd0,  32'h0,        4'hF, 32'h0},  // R1 ctl
    '{K_RD, 4'd2,  32'h0,        4'hF, 32'h0},  // R1 mask
    '{K_RD, 4'd1,  32'h0,        4'hF, 32'h0},  // R1 status
    '{K_RD, 4'd8,  32'h0,        4'hF, 32'h0},  // R1 cnt0
    '{K_EV, 4'd0,  32'h0505,     4'h0, 32'h0},
    '{K_RD, 4'd8,  32'h0,        4'hF, 32'd5},  // R3
    '{K_RD, 4'd10, 32'h0,        4'hF, 32'd5},  // R3
    '{K_RD, 4'd9,  32'h0,        4'hF, 32'd0},  // R3
    '{K_RD, 4'd8,  32'h0,        4'hE, 32'd0},  // R3 lane gating
    '{K_WR, 4'd0,  32'h8,        4'h0, 32'h0},
    '{K_EV, 4'd0,  32'h030F,     4'h0, 32'h0},
    '{K_RD, 4'd8,  32'h0,        4'hF, 32'd5},  // R4
    '{K_RD, 4'd11, 32'h0,        4'hF, 32'd0},  // R4
    '{K_WR, 4'd0,  32'hFFFFFFF4, 4'h0, 32'h0},
    '{K_RD, 4'd0,  32'h0,        4'hF, 32'h4},  // R12
    '{K_EV, 4'd0,  32'h0201,     4'h0, 32'h0},
    '{K_RD, 4'd8,  32'h0,        4'hF, 32'd7},  // R11
    '{K_RD, 4'd8,  32'h0,        4'hF, 32'd0},  // R11
    '{K_RD, 4'd10, 32'h0,        4'hE, 32'd0},  // R11
    '{K_WR, 4'd0,  32'h0,        4'h0, 32'h0},
    '{K_RD, 4'd10, 32'h0,        4'hF, 32'd5},  // R11
    '{K_WR, 4'd10, 32'h77,       4'h0, 32'h0},
    '{K_RD, 4'd10, 32'h0,        4'hF, 32'd5},  // R12
    '{K_WR, 4'd1,  32'hF,        4'h0, 32'h0},
    '{K_RD, 4'd1,  32'h0,        4'hF, 32'd0}   // R12
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N_CTR-1:0]  evt_i;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [3:0]        rd_lane;
  logic [31:0]       rdata;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_ctr_bank #(.N_CTR(N_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) i_stat_ctr_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_lane(rd_lane), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] ln, output logic [31:0] q);
    rd_en = 1'b1; addr = a; rd_lane = ln;
    @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      evt_i = m;
      @(negedge clk);
    end
    evt_i = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    rst_n = 1'b0; evt_i = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; rd_lane = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq", {31'b0, irq}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v].kind)
        K_WR: wr(VEC[v].adr, VEC[v].data);
        K_EV: pulse(VEC[v].data[3:0], int'(VEC[v].data[15:8]));
        default: begin
          rd(VEC[v].adr, VEC[v].lane, q);
          check($sformatf("vec%0d", v), q, VEC[v].exp);
        end
      endcase
    end

    // Half-range flag, wrap, status persistence, mask (R6 R7 R8 R9)
    pulse(4'b0010, 128);
    check("R9 irq up", {31'b0, irq}, 32'd1);
    rd(4'd1, 4'hF, q); check("R7 status", q, 32'h2);
    pulse(4'b0010, 128);
    rd(4'd1, 4'hF, q); check("R8 kept after wrap", q, 32'h2);
    rd(4'd9, 4'hE, q); check("R8 no-lane0 read", q, 32'h0);
    rd(4'd1, 4'hF, q); check("R8 still set", q, 32'h2);
    wr(4'd2, 32'h2);
    check("R9 masked", {31'b0, irq}, 32'd0);
    wr(4'd2, 32'h0);
    check("R9 unmasked", {31'b0, irq}, 32'd1);
    rd(4'd9, 4'h1, q); check("R6 wrapped", q, 32'h0);
    rd(4'd1, 4'hF, q); check("R8 cleared", q, 32'h0);
    check("R9 irq down", {31'b0, irq}, 32'd0);

    // Saturation (R5)
    wr(4'd0, 32'h2);
    pulse(4'b1000, 260);
    rd(4'd11, 4'hF, q); check("R5 saturate", q, 32'hFF);
    rd(4'd11, 4'hF, q); check("R5 held", q, 32'hFF);

    // Global clear (R2)
    wr(4'd0, 32'h3);
    rd(4'd0, 4'hF, q); check("R2 bit live", q, 32'h3);
    rd(4'd0, 4'hF, q); check("R2 self clear", q, 32'h2);
    rd(4'd11, 4'hF, q); check("R2 cnt3", q, 32'h0);
    rd(4'd10, 4'hF, q); check("R2 cnt2", q, 32'h0);

    // Event and clearing read in one clock (R10)
    wr(4'd0, 32'h4);
    pulse(4'b0001, 3);
    rd_en = 1'b1; addr = 4'd8; rd_lane = 4'hF; evt_i = 4'b0001;
    @(negedge clk);
    rd_en = 1'b0; evt_i = '0;
    check("R10 pre-clear value", rdata, 32'd3);
    rd(4'd8, 4'hF, q); check("R10 ends at 1", q, 32'd1);

    // Clear on read under freeze (R11, R4)
    pulse(4'b0001, 4);
    wr(4'd0, 32'hC);
    rd(4'd8, 4'hF, q); check("R11 frozen value", q, 32'd4);
    pulse(4'b0001, 2);
    rd(4'd8, 4'hF, q); check("R11 cleared under freeze", q, 32'd0);

    summary();
    done = 1;
    $finish;
  end

endmodule